// File: doc/BRIEF.md
# Windowed Interrupt Controller Register File

This block is the register file of an I/O interrupt controller. A host reaches it through a two-word bus window. It first writes a register number into a select register. It then reads or writes the chosen internal register through a data window. Behind the window sit the following registers:

- an identification register;
- a read-only version register;
- an arbitration identifier;
- a redirection table with one 64-bit entry for each interrupt input, reached as two 32-bit halves.

Routing logic elsewhere in the controller reads whole table entries through a separate combinational port. Bus reads are registered, and the result appears one cycle after the request. Illegal bus accesses raise an error flag. Accesses through the window to unmapped register numbers raise a warning flag.

Top module: `irq_window_regs`

## Requirements
- R1: A request is legal only when `bus_be` is 4'hF and `bus_addr` is 0x00 or 0x10. Any other request sets `bus_err` in the following cycle, changes no state, and returns 0 as read data.
- R2: A write at offset 0x00 stores `bus_wdata[7:0]` as the register select. A read at 0x00 returns the select value zero-extended. After reset the select is 0.
- R3: `bus_rdata`, `bus_err` and `bus_warn` are registered and reflect a request in the cycle after it. `bus_rdata` holds its value until the next read request. `bus_err` and `bus_warn` are low in any cycle that follows a cycle without a request.
- R4: Register 0x00 holds a 4-bit identifier. It reads as the identifier in bits 27:24 with every other bit 0, and a write keeps only `bus_wdata[27:24]`. After reset the identifier is `ID_RESET`.
- R5: Register 0x01 reads as {8'h00, NUM_ENTRIES-1 (8 bits), 8'h00, VERSION}, which is 32'h0017_0020 with default parameters. Writes to it change nothing.
- R6: Register 0x02 holds a 4-bit arbitration identifier with the same bit packing as R4. After reset it equals `ID_RESET`, and it is independent of later identifier writes.
- R7: Register 0x10+2k reaches bits 31:0 of table entry k, and register 0x11+2k reaches bits 63:32 of entry k, for k from 0 to NUM_ENTRIES-1 (registers 0x10 to 0x3F by default).
- R8: Reserved entry bits are stored as zero on every write. These are bits 31:17 of the lower half (mask 32'hFFFE_0000) and bits 23:0 of the upper half (mask 32'h00FF_FFFF).
- R9: Registers 0x03 to 0x0F and those at or above 0x10+2*NUM_ENTRIES are undefined. A window read of one returns 0, a window write to one changes nothing, and either access sets `bus_warn` in the following cycle.
- R10: `route_entry` shows table entry `route_idx` combinationally and is 0 when `route_idx` is NUM_ENTRIES or above.
- R11: After reset every table entry is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset inside the block |
| bus_be | input | 4 | Byte enables; only 4'hF is legal |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | Illegal access flag, one cycle after the request |
| bus_warn | output | 1 | Undefined-register flag, one cycle after the request |
| route_idx | input | 5 | Entry index for the routing read port |
| route_entry | output | 64 | Table entry selected by `route_idx` |

## Verification
The assertions assume that `bus_addr`, `bus_be`, `bus_we` and `bus_wdata` are meaningful only while `bus_req` is high. They also assume that a request occupies exactly one cycle, so the flags and read data can be tied to the single preceding cycle. The stimulus respects this. Inputs change only on falling edges, every access is a one-cycle pulse, and outputs are sampled on the falling edge after the capturing rising edge. Illegal offsets, partial byte enables and undefined register numbers are issued deliberately, and each is followed by a read that shows the state was left untouched.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;

    localparam logic [31:0] LO_RSV_MASK = 32'hFFFE_0000;
    localparam logic [31:0] HI_RSV_MASK = 32'h00FF_FFFF;
    localparam logic [7:0]  WIN_SEL_OFF  = 8'h00;
    localparam logic [7:0]  WIN_DATA_OFF = 8'h10;
    localparam int          TBL_BASE     = 16;

    typedef struct packed {
        logic [14:0] rsv;
        logic        masked;
        logic        level_trig;
        logic        remote_ack;
        logic        active_low;
        logic        pending;
        logic        logical_dst;
        logic [2:0]  dlv_mode;
        logic [7:0]  vec;
    } redir_lo_t;

    typedef struct packed {
        logic [7:0]  dst;
        logic [23:0] rsv;
    } redir_hi_t;

    typedef struct packed {
        redir_hi_t hi;
        redir_lo_t lo;
    } redir_entry_t;

    typedef enum logic [2:0] {
        RK_IDENT,
        RK_VERSION,
        RK_ARB,
        RK_TBL_LO,
        RK_TBL_HI,
        RK_UNDEF
    } reg_kind_e;

    function automatic redir_lo_t scrub_lo(input logic [31:0] w);
        return redir_lo_t'(w & ~LO_RSV_MASK);
    endfunction

    function automatic redir_hi_t scrub_hi(input logic [31:0] w);
        return redir_hi_t'(w & ~HI_RSV_MASK);
    endfunction

    function automatic logic [31:0] pack_id(input logic [3:0] v);
        return {4'h0, v, 24'h0};
    endfunction

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import irq_regs_pkg::*;
#(
    parameter int NUM_ENTRIES = 24,
    parameter int SEL_W       = 8,
    localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
    input  logic [SEL_W-1:0] sel,
    output reg_kind_e        kind,
    output logic [IDX_W-1:0] idx
);
    localparam int TBL_END = TBL_BASE + 2 * NUM_ENTRIES;

    logic [SEL_W-1:0] rel;

    always_comb begin
        rel  = sel - SEL_W'(TBL_BASE);
        kind = RK_UNDEF;
        idx  = '0;
        if (sel == SEL_W'(0)) begin
            kind = RK_IDENT;
        end else if (sel == SEL_W'(1)) begin
            kind = RK_VERSION;
        end else if (sel == SEL_W'(2)) begin
            kind = RK_ARB;
        end else if (32'(sel) >= 32'(TBL_BASE) && 32'(sel) < 32'(TBL_END)) begin
            kind = sel[0] ? RK_TBL_HI : RK_TBL_LO;
            idx  = IDX_W'(rel[SEL_W-1:1]);
        end
    end
endmodule

// File: rtl/irq_redir_table.sv
module irq_redir_table
    import irq_regs_pkg::*;
#(
    parameter int NUM_ENTRIES = 24,
    localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_hi,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_data,
    input  logic             rd_hi,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rd_data,
    input  logic [IDX_W-1:0] route_idx,
    output redir_entry_t     route_entry
);
    redir_entry_t ent [NUM_ENTRIES];

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ent[g] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                if (wr_hi) ent[g].hi <= scrub_hi(wr_data);
                else       ent[g].lo <= scrub_lo(wr_data);
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (32'(rd_idx) < NUM_ENTRIES)
            rd_data = rd_hi ? 32'(ent[rd_idx].hi) : 32'(ent[rd_idx].lo);
        route_entry = '0;
        if (32'(route_idx) < NUM_ENTRIES)
            route_entry = ent[route_idx];
    end

    // R8
    rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (route_entry.lo.rsv == '0) && (route_entry.hi.rsv == '0));

    // R10
    route_range_chk: assert property (@(posedge clk) disable iff (rst)
        (32'(route_idx) >= NUM_ENTRIES) |-> (route_entry == '0));
endmodule

// File: rtl/irq_window_regs.sv
module irq_window_regs
    import irq_regs_pkg::*;
#(
    parameter int          NUM_ENTRIES = 24,
    parameter logic [3:0]  ID_RESET    = 4'h2,
    parameter logic [7:0]  VERSION     = 8'h20,
    localparam int         IDX_W       = $clog2(NUM_ENTRIES),
    localparam int         SEL_W       = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_req,
    input  logic             bus_we,
    input  logic [7:0]       bus_addr,
    input  logic [3:0]       bus_be,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    output logic             bus_err,
    output logic             bus_warn,
    input  logic [IDX_W-1:0] route_idx,
    output logic [63:0]      route_entry
);
    localparam logic [31:0] VER_WORD = {8'h00, 8'(NUM_ENTRIES - 1), 8'h00, VERSION};

    logic [SEL_W-1:0] sel_q;
    logic [3:0]       id_q, arb_q;
    logic [31:0]      rdata_q;
    logic             err_q, warn_q;

    reg_kind_e        kind;
    logic [IDX_W-1:0] tidx;
    logic [31:0]      tbl_rd;
    redir_entry_t     route_s;

    logic legal, sel_acc, win_acc, tbl_we;
    logic [31:0] rd_mux;

    irq_reg_decode #(.NUM_ENTRIES(NUM_ENTRIES), .SEL_W(SEL_W)) u_dec (
        .sel  (sel_q),
        .kind (kind),
        .idx  (tidx)
    );

    assign legal   = bus_req && (bus_be == 4'hF) &&
                     (bus_addr == WIN_SEL_OFF || bus_addr == WIN_DATA_OFF);
    assign sel_acc = legal && (bus_addr == WIN_SEL_OFF);
    assign win_acc = legal && (bus_addr == WIN_DATA_OFF);
    assign tbl_we  = win_acc && bus_we && (kind == RK_TBL_LO || kind == RK_TBL_HI);

    irq_redir_table #(.NUM_ENTRIES(NUM_ENTRIES)) u_tbl (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (tbl_we),
        .wr_hi       (kind == RK_TBL_HI),
        .wr_idx      (tidx),
        .wr_data     (bus_wdata),
        .rd_hi       (kind == RK_TBL_HI),
        .rd_idx      (tidx),
        .rd_data     (tbl_rd),
        .route_idx   (route_idx),
        .route_entry (route_s)
    );

    always_comb begin
        rd_mux = '0;
        if (sel_acc) begin
            rd_mux = 32'(sel_q);
        end else begin
            unique case (kind)
                RK_IDENT:             rd_mux = pack_id(id_q);
                RK_VERSION:           rd_mux = VER_WORD;
                RK_ARB:               rd_mux = pack_id(arb_q);
                RK_TBL_LO, RK_TBL_HI: rd_mux = tbl_rd;
                default:              rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= '0;
            id_q    <= ID_RESET;
            arb_q   <= ID_RESET;
            rdata_q <= '0;
            err_q   <= 1'b0;
            warn_q  <= 1'b0;
        end else begin
            err_q  <= bus_req && !legal;
            warn_q <= win_acc && (kind == RK_UNDEF);
            if (bus_req && !bus_we)
                rdata_q <= legal ? rd_mux : '0;
            if (sel_acc && bus_we)
                sel_q <= bus_wdata[SEL_W-1:0];
            if (win_acc && bus_we) begin
                if (kind == RK_IDENT) id_q  <= bus_wdata[27:24];
                if (kind == RK_ARB)   arb_q <= bus_wdata[27:24];
            end
        end
    end

    assign bus_rdata   = rdata_q;
    assign bus_err     = err_q;
    assign bus_warn    = warn_q;
    assign route_entry = route_s;

    // R1
    bad_access_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && (bus_be != 4'hF)) |=> bus_err);

    // R2
    sel_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && bus_be == 4'hF && bus_addr == 8'h00)
        |=> (sel_q == $past(bus_wdata[7:0])));

    // R3
    idle_flags_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_req |=> (!bus_err && !bus_warn));

    // R3
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_req && !bus_we) |=> $stable(bus_rdata));

    // R4
    id_write_chk: assert property (@(posedge clk) disable iff (rst)
        (win_acc && bus_we && sel_q == 8'h00) |=> (id_q == $past(bus_wdata[27:24])));

    // R9
    flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_err && bus_warn));
endmodule

// File: tb/irq_window_regs_tb.sv
module irq_window_regs_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] EXP_VER = 32'h0017_0020;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err, bus_warn;
    logic [4:0]  route_idx = '0;
    logic [63:0] route_entry;

    int n_vec = 0, n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_window_regs u_dut (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .bus_warn(bus_warn),
        .route_idx(route_idx), .route_entry(route_entry)
    );

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic access(input logic we, input logic [7:0] addr,
                          input logic [3:0] be, input logic [31:0] wd);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = addr; bus_be = be; bus_wdata = wd;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic wr_reg(input logic [7:0] r, input logic [31:0] d);
        access(1'b1, 8'h00, 4'hF, {24'h0, r});
        access(1'b1, 8'h10, 4'hF, d);
    endtask

    task automatic rd_reg(input logic [7:0] r);
        access(1'b1, 8'h00, 4'hF, {24'h0, r});
        access(1'b0, 8'h10, 4'hF, '0);
    endtask

    task automatic t_reset;
        access(1'b0, 8'h00, 4'hF, '0);
        check("R2 select reset", bus_rdata, 0);
        rd_reg(8'h00);
        check("R4 id reset", bus_rdata, 32'h0200_0000);
        rd_reg(8'h02);
        check("R6 arb reset", bus_rdata, 32'h0200_0000);
        route_idx = 5'd0;  #1 check("R11 entry0 reset", route_entry, 0);
        route_idx = 5'd23; #1 check("R11 entry23 reset", route_entry, 0);
    endtask

    task automatic t_ident;
        access(1'b1, 8'h00, 4'hF, 32'hFFFF_FF3C);
        access(1'b0, 8'h00, 4'hF, '0);
        check("R2 select readback", bus_rdata, 32'h0000_003C);
        wr_reg(8'h00, 32'hFFFF_FFFF);
        rd_reg(8'h00);
        check("R4 id packing", bus_rdata, 32'h0F00_0000);
        rd_reg(8'h02);
        check("R6 arb independent of id", bus_rdata, 32'h0200_0000);
        wr_reg(8'h02, 32'h5A5A_5A5A);
        rd_reg(8'h02);
        check("R6 arb packing", bus_rdata, 32'h0A00_0000);
        rd_reg(8'h01);
        check("R5 version", bus_rdata, EXP_VER);
        wr_reg(8'h01, 32'hDEAD_BEEF);
        rd_reg(8'h01);
        check("R5 version write ignored", bus_rdata, EXP_VER);
    endtask

    task automatic t_table;
        wr_reg(8'h10, 32'hFFFF_FFFF);
        rd_reg(8'h10);
        check("R8 low rsv cleared", bus_rdata, 32'h0001_FFFF);
        wr_reg(8'h11, 32'hFFFF_FFFF);
        rd_reg(8'h11);
        check("R8 high rsv cleared", bus_rdata, 32'hFF00_0000);
        route_idx = 5'd0; #1
        check("R10 entry0 route", route_entry, 64'hFF00_0000_0001_FFFF);
        wr_reg(8'h3E, 32'h0001_A5C3);
        wr_reg(8'h3F, 32'hAB00_1234);
        route_idx = 5'd23; #1
        check("R7 entry23 halves", route_entry, 64'hAB00_0000_0001_A5C3);
        route_idx = 5'd1; #1
        check("R7 entry1 untouched", route_entry, 0);
        route_idx = 5'd24; #1
        check("R10 out of range idx", route_entry, 0);
    endtask

    task automatic t_undef;
        rd_reg(8'h03);
        check("R9 undef read data", bus_rdata, 0);
        check("R9 undef read warn", {63'h0, bus_warn}, 1);
        wr_reg(8'h40, 32'hFFFF_FFFF);
        check("R9 undef write warn", {63'h0, bus_warn}, 1);
        route_idx = 5'd23; #1
        check("R9 undef write no effect", route_entry, 64'hAB00_0000_0001_A5C3);
        wr_reg(8'h0F, 32'hFFFF_FFFF);
        rd_reg(8'h00);
        check("R9 id untouched by undef write", bus_rdata, 32'h0F00_0000);
        check("R9 no warn on defined reg", {63'h0, bus_warn}, 0);
    endtask

    task automatic t_errors;
        access(1'b0, 8'h04, 4'hF, '0);
        check("R1 bad offset read err", {63'h0, bus_err}, 1);
        check("R1 bad offset read data", bus_rdata, 0);
        access(1'b1, 8'h00, 4'hF, 32'h0000_0055);
        access(1'b1, 8'h08, 4'hF, 32'h0000_0011);
        check("R1 bad offset write err", {63'h0, bus_err}, 1);
        access(1'b1, 8'h00, 4'h3, 32'h0000_0022);
        check("R1 partial be err", {63'h0, bus_err}, 1);
        access(1'b0, 8'h00, 4'hF, '0);
        check("R1 select unchanged", bus_rdata, 32'h0000_0055);
        check("R1 legal access no err", {63'h0, bus_err}, 0);
    endtask

    task automatic t_timing;
        rd_reg(8'h01);
        @(negedge clk);
        check("R3 rdata holds when idle", bus_rdata, EXP_VER);
        access(1'b0, 8'h0C, 4'hF, '0);
        @(negedge clk);
        check("R3 err low after idle", {63'h0, bus_err}, 0);
        wr_reg(8'h02, 32'h0300_0000);
        check("R3 rdata held over writes", bus_rdata, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_ident;
        t_table;
        t_undef;
        t_errors;
        t_timing;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_vec++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule